// File: doc/BRIEF.md
# Beat Response Merger for an AXI Bridge

This unit sits between the data-phase side of an AHB master and the two AXI response channels of a bridge. Each cycle in which an AHB data phase completes, it receives the slave's error indication and exclusive-success flag for that beat. It classifies the beat into an AXI response code and folds it into a running result for the channel the beat belongs to. A write burst gives a single merged B response. A read beat gives its own R response. When one unaligned AXI read beat has been split into several AHB accesses, those accesses are merged into one R response.

Merging keeps the worst response seen, with the ranking SLVERR worst, then OKAY, then EXOKAY. On the write side, the unit also detects two conditions that the bridge cannot honour. The first is a strobe pattern that contradicts the sparse flag. The second is a single exclusive write that is marked sparse. In both cases the beat still completes normally, and the resulting B response is forced to SLVERR. The unit holds no data and does no sequencing. Queuing of the responses is left to the surrounding logic.

Top module: `resp_merge`

## Requirements
- R1: Every write beat presented with `beat_last` HIGH gives exactly one `b_vld` pulse on the following cycle. `b_vld` is LOW in every other cycle.
- R2: Response codes are OKAY=2'b00, EXOKAY=2'b01 and SLVERR=2'b10. The code 2'b11 never appears on `b_resp` or `r_resp` while the matching valid is HIGH.
- R3: A merged response equals the worst beat code among the beats it covers. The ranking is SLVERR worse than OKAY, and OKAY worse than EXOKAY. The order in which the beats arrive does not change the result.
- R4: After each response is issued, the merge restarts. The result of one burst or split group never influences the next one on the same channel.
- R5: A read beat with `beat_last` HIGH gives one `r_vld` pulse on the following cycle. Read beats with `beat_last` LOW (parts of a split access) give no pulse. They are merged into the next read response.
- R6: On a write beat with `wr_sparse` LOW and any `wr_strb` bit LOW, the burst's B response is SLVERR. The B response is still issued at the usual time.
- R7: On a write beat with `beat_excl`, `wr_single` and `wr_sparse` all HIGH, the burst's B response is SLVERR.
- R8: For a non-exclusive beat (`beat_excl` LOW), the code is SLVERR when `beat_err` is HIGH and OKAY otherwise. `beat_exok` has no effect.
- R9: For an exclusive beat, the code is SLVERR when `beat_err` is HIGH. Otherwise it is EXOKAY when `beat_exok` is HIGH and OKAY when `beat_exok` is LOW.
- R10: `wr_sparse`, `wr_single` and `wr_strb` have no effect on read beats. Inputs in cycles with `beat_vld` LOW have no effect on either channel.
- R11: While reset is held, and for two cycles after it is released, `b_vld` and `r_vld` are LOW. The first burst after reset starts from an empty merge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_vld | input | 1 | An AHB data phase completes this cycle |
| beat_wr | input | 1 | The completing beat is a write (HIGH) or a read (LOW) |
| beat_last | input | 1 | Last beat of the write burst, or last access of a read beat |
| beat_excl | input | 1 | The beat is an exclusive access |
| beat_err | input | 1 | AHB slave returned ERROR for the beat |
| beat_exok | input | 1 | AHB slave signalled exclusive success |
| wr_sparse | input | 1 | The write burst is declared sparse |
| wr_single | input | 1 | The write is a single-beat transaction |
| wr_strb | input | STRB_W | Byte strobes of the write beat |
| b_vld | output | 1 | Merged write response valid |
| b_resp | output | 2 | Merged write response code |
| r_vld | output | 1 | Read response valid |
| r_resp | output | 2 | Read response code |

## Verification
Write bursts are driven with the worst beat placed first, in the middle and last. This shows whether the merge is a true worst-of or only remembers an end value. A clean burst follows an erroring one to show that the merge restarts. Exclusive and non-exclusive beats are sent with every combination of error and exclusive-success flags, which separates the two mapping tables. Strobe, sparse and single patterns are applied to both writes and reads, which separates a real internal-error check from one that leaks into the read channel. Read beats are interleaved between write beats, and split read groups are mixed with plain read beats. A long pseudo-random run compares every cycle against a behavioural model.

// File: rtl/resp_merge_pkg.sv
package resp_merge_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY   = 2'b00,
    RSP_EXOKAY = 2'b01,
    RSP_SLVERR = 2'b10
  } axi_rsp_e;

  // Value an empty merge starts from: the least severe code.
  localparam axi_rsp_e RSP_EMPTY = RSP_EXOKAY;

  // Severity rank: higher is worse.
  function automatic logic [1:0] rsp_rank(input axi_rsp_e r);
    logic [1:0] k;
    case (r)
      RSP_EXOKAY: k = 2'd0;
      RSP_OKAY:   k = 2'd1;
      default:    k = 2'd2;
    endcase
    return k;
  endfunction

  function automatic axi_rsp_e rsp_worse(input axi_rsp_e a, input axi_rsp_e b);
    return (rsp_rank(a) >= rsp_rank(b)) ? a : b;
  endfunction

endpackage

// File: rtl/resp_beat_map.sv
module resp_beat_map
  import resp_merge_pkg::*;
(
  input  logic     excl,
  input  logic     slv_err,
  input  logic     exok,
  input  logic     force_err,
  output axi_rsp_e code
);

  always_comb begin
    if (slv_err || force_err) begin
      code = RSP_SLVERR;
    end else if (excl && exok) begin
      code = RSP_EXOKAY;
    end else begin
      code = RSP_OKAY;
    end
  end

endmodule

// File: rtl/resp_wr_check.sv
module resp_wr_check #(
  parameter int STRB_W = 4
) (
  input  logic              sparse,
  input  logic              single,
  input  logic              excl,
  input  logic [STRB_W-1:0] strb,
  output logic              int_err
);

  logic strb_gap;
  logic excl_sparse;

  always_comb begin
    strb_gap    = ~(&strb);
    excl_sparse = excl && single && sparse;
    int_err     = (!sparse && strb_gap) || excl_sparse;
  end

endmodule

// File: rtl/resp_accum.sv
module resp_accum
  import resp_merge_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_vld,
  input  logic     in_last,
  input  axi_rsp_e in_code,
  output logic     out_vld,
  output axi_rsp_e out_code
);

  axi_rsp_e acc_q, acc_d;
  logic     vld_q, vld_d;
  axi_rsp_e res_q, res_d;
  logic     acc_en, res_en;
  axi_rsp_e merged;

  always_comb begin
    merged = rsp_worse(acc_q, in_code);
    acc_en = in_vld;
    acc_d  = in_last ? RSP_EMPTY : merged;
    vld_d  = in_vld && in_last;
    res_en = in_vld && in_last;
    res_d  = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= RSP_EMPTY;
      vld_q <= 1'b0;
      res_q <= RSP_OKAY;
    end else begin
      vld_q <= vld_d;
      if (acc_en) acc_q <= acc_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign out_vld  = vld_q;
  assign out_code = res_q;

endmodule

// File: rtl/resp_merge.sv
module resp_merge
  import resp_merge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_vld,
  input  logic              beat_wr,
  input  logic              beat_last,
  input  logic              beat_excl,
  input  logic              beat_err,
  input  logic              beat_exok,
  input  logic              wr_sparse,
  input  logic              wr_single,
  input  logic [STRB_W-1:0] wr_strb,
  output logic              b_vld,
  output logic [1:0]        b_resp,
  output logic              r_vld,
  output logic [1:0]        r_resp
);

  localparam int NCH   = 2;
  localparam int CH_RD = 0;
  localparam int CH_WR = 1;
  localparam int SYNC_N = 2;

  // Reset: asserted asynchronously, released after SYNC_N edges.
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_s = rst_pipe[SYNC_N-1];

  logic wr_int_err;

  resp_wr_check #(.STRB_W(STRB_W)) u_wchk (
    .sparse  (wr_sparse),
    .single  (wr_single),
    .excl    (beat_excl),
    .strb    (wr_strb),
    .int_err (wr_int_err)
  );

  logic     ch_out_vld [NCH];
  axi_rsp_e ch_out_code[NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam bit IS_WR = (ch == CH_WR);
    logic     sel_vld;
    logic     frc;
    axi_rsp_e code;

    assign sel_vld = beat_vld && (beat_wr == IS_WR);
    assign frc     = IS_WR ? wr_int_err : 1'b0;

    resp_beat_map u_map (
      .excl      (beat_excl),
      .slv_err   (beat_err),
      .exok      (beat_exok),
      .force_err (frc),
      .code      (code)
    );

    resp_accum u_acc (
      .clk      (clk),
      .rst_n    (rst_s),
      .in_vld   (sel_vld),
      .in_last  (beat_last),
      .in_code  (code),
      .out_vld  (ch_out_vld[ch]),
      .out_code (ch_out_code[ch])
    );
  end

  assign b_vld  = ch_out_vld[CH_WR];
  assign b_resp = ch_out_code[CH_WR];
  assign r_vld  = ch_out_vld[CH_RD];
  assign r_resp = ch_out_code[CH_RD];

endmodule

// File: rtl/resp_merge_chk.sv
module resp_merge_chk #(
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst_s,
  input logic              beat_vld,
  input logic              beat_wr,
  input logic              beat_last,
  input logic              beat_excl,
  input logic              beat_err,
  input logic              wr_sparse,
  input logic              wr_single,
  input logic [STRB_W-1:0] wr_strb,
  input logic              b_vld,
  input logic [1:0]        b_resp,
  input logic              r_vld,
  input logic [1:0]        r_resp
);

  p_b_after_last_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld && beat_wr && beat_last) |=> b_vld);

  p_b_only_after_last_r1: assert property (@(posedge clk) disable iff (!rst_s)
    b_vld |-> $past(beat_vld && beat_wr && beat_last));

  p_b_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_s)
    b_vld |-> (b_resp != 2'b11));

  p_r_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_s)
    r_vld |-> (r_resp != 2'b11));

  p_r_after_last_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld && !beat_wr && beat_last) |=> r_vld);

  p_r_only_after_last_r5: assert property (@(posedge clk) disable iff (!rst_s)
    r_vld |-> $past(beat_vld && !beat_wr && beat_last));

  p_strobe_clash_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld && beat_wr && beat_last && !wr_sparse && !(&wr_strb))
      |=> (b_vld && b_resp == 2'b10));

  p_excl_sparse_single_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld && beat_wr && beat_last && beat_excl && wr_single && wr_sparse)
      |=> (b_vld && b_resp == 2'b10));

  p_rd_err_slverr_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (beat_vld && !beat_wr && beat_last && beat_err) |=> (r_resp == 2'b10));

  p_rd_exok_needs_excl_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (r_vld && r_resp == 2'b01) |-> $past(beat_excl));

endmodule

bind resp_merge resp_merge_chk #(.STRB_W(STRB_W)) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .beat_vld  (beat_vld),
  .beat_wr   (beat_wr),
  .beat_last (beat_last),
  .beat_excl (beat_excl),
  .beat_err  (beat_err),
  .wr_sparse (wr_sparse),
  .wr_single (wr_single),
  .wr_strb   (wr_strb),
  .b_vld     (b_vld),
  .b_resp    (b_resp),
  .r_vld     (r_vld),
  .r_resp    (r_resp)
);

// File: tb/sim_resp_merge.sv
module sim_resp_merge;

  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam logic [STRB_W-1:0] FULL = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic beat_vld = 0, beat_wr = 0, beat_last = 0, beat_excl = 0;
  logic beat_err = 0, beat_exok = 0, wr_sparse = 0, wr_single = 0;
  logic [STRB_W-1:0] wr_strb = '1;
  logic b_vld, r_vld;
  logic [1:0] b_resp, r_resp;

  always #(CLK_P/2) clk = ~clk;

  resp_merge #(.DATA_W(DATA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .beat_vld(beat_vld), .beat_wr(beat_wr),
    .beat_last(beat_last), .beat_excl(beat_excl), .beat_err(beat_err),
    .beat_exok(beat_exok), .wr_sparse(wr_sparse), .wr_single(wr_single),
    .wr_strb(wr_strb), .b_vld(b_vld), .b_resp(b_resp), .r_vld(r_vld),
    .r_resp(r_resp)
  );

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // Behavioural model: severity ranks 0=EXOKAY 1=OKAY 2=SLVERR.
  int acc_w = 0, acc_r = 0;
  bit exp_bv = 0, exp_rv = 0;
  logic [1:0] exp_b = 0, exp_r = 0;
  string last_tag = "R11";

  function automatic logic [1:0] code_of(int rank);
    return (rank == 0) ? 2'b01 : (rank == 1) ? 2'b00 : 2'b10;
  endfunction

  task automatic compare();
    vectors++;
    if (b_vld !== exp_bv || (exp_bv && b_resp !== exp_b)) begin
      fails++;
      $display("FAIL %s: b_vld/b_resp = %0b/%0b expected %0b/%0b",
               last_tag, b_vld, b_resp, exp_bv, exp_b);
    end
    if (r_vld !== exp_rv || (exp_rv && r_resp !== exp_r)) begin
      fails++;
      $display("FAIL %s: r_vld/r_resp = %0b/%0b expected %0b/%0b",
               last_tag, r_vld, r_resp, exp_rv, exp_r);
    end
  endtask

  task automatic beat(input string tag, input bit vld, input bit wr,
                      input bit last, input bit excl, input bit err,
                      input bit exok, input bit sparse, input bit single,
                      input logic [STRB_W-1:0] strb);
    int rank;
    @(negedge clk);
    compare();
    last_tag = tag;
    beat_vld = vld; beat_wr = wr; beat_last = last; beat_excl = excl;
    beat_err = err; beat_exok = exok; wr_sparse = sparse;
    wr_single = single; wr_strb = strb;
    exp_bv = 0; exp_rv = 0;
    if (vld) begin
      rank = err ? 2 : (excl && exok) ? 0 : 1;
      if (wr && ((!sparse && strb != FULL) || (excl && single && sparse)))
        rank = 2;
      if (wr) begin
        if (rank > acc_w) acc_w = rank;
        if (last) begin exp_bv = 1; exp_b = code_of(acc_w); acc_w = 0; end
      end else begin
        if (rank > acc_r) acc_r = rank;
        if (last) begin exp_rv = 1; exp_r = code_of(acc_r); acc_r = 0; end
      end
    end
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) beat(tag, 0, 0, 0, 0, 0, 0, 0, 0, FULL);
  endtask

  // Shorthand: write / read beat with full strobes, not sparse, not single.
  task automatic wb(input string tag, input bit last, input bit excl,
                    input bit err, input bit exok);
    beat(tag, 1, 1, last, excl, err, exok, 0, 0, FULL);
  endtask

  task automatic rb(input string tag, input bit last, input bit excl,
                    input bit err, input bit exok);
    beat(tag, 1, 0, last, excl, err, exok, 0, 0, FULL);
  endtask

  initial begin
    // R11: outputs low during reset and the synchroniser window
    repeat (3) begin @(negedge clk); compare(); end
    rst_n = 1'b1;
    idle("R11", 3);

    // R1, R8: single non-exclusive writes
    wb("R1", 1, 0, 0, 0);
    wb("R8", 1, 0, 1, 0);
    wb("R8", 1, 0, 0, 1);
    idle("R1", 1);

    // R3: worst beat first, middle, last
    wb("R3", 0, 0, 1, 0); wb("R3", 0, 0, 0, 0); wb("R3", 1, 0, 0, 0);
    wb("R3", 0, 0, 0, 0); wb("R3", 0, 0, 1, 0); wb("R3", 1, 0, 0, 0);
    wb("R3", 0, 0, 0, 0); wb("R3", 0, 0, 0, 0); wb("R3", 1, 0, 1, 0);
    // R4: clean burst after an erroring one
    wb("R4", 0, 0, 0, 0); wb("R4", 1, 0, 0, 0);

    // R9: exclusive writes
    wb("R9", 0, 1, 0, 1); wb("R9", 1, 1, 0, 1);
    wb("R9", 0, 1, 0, 1); wb("R9", 1, 1, 0, 0);
    wb("R9", 0, 1, 0, 1); wb("R9", 1, 1, 1, 1);
    wb("R4", 1, 1, 0, 1);

    // R6: strobe holes without sparse; with sparse they are fine
    beat("R6", 1, 1, 0, 0, 0, 0, 0, 0, 4'b1011);
    beat("R6", 1, 1, 1, 0, 0, 0, 0, 0, FULL);
    beat("R6", 1, 1, 1, 0, 0, 0, 1, 0, 4'b0010);
    beat("R6", 1, 1, 1, 0, 0, 0, 0, 1, 4'b0111);

    // R7: single sparse exclusive write
    beat("R7", 1, 1, 1, 1, 0, 1, 1, 1, FULL);
    beat("R7", 1, 1, 1, 0, 0, 0, 1, 1, FULL);
    beat("R7", 1, 1, 0, 1, 0, 1, 1, 0, FULL);
    beat("R7", 1, 1, 1, 1, 0, 1, 1, 0, FULL);

    // R5, R8, R9: read beats
    rb("R5", 1, 0, 0, 0); rb("R5", 1, 0, 1, 0); rb("R8", 1, 0, 0, 1);
    rb("R9", 1, 1, 0, 1); rb("R9", 1, 1, 0, 0); rb("R9", 1, 1, 1, 1);
    // R5: split groups
    rb("R5", 0, 1, 0, 1); rb("R5", 0, 1, 0, 0); rb("R5", 1, 1, 0, 1);
    rb("R5", 0, 1, 0, 1); rb("R5", 1, 1, 0, 1);
    rb("R5", 0, 0, 1, 0); rb("R5", 1, 0, 0, 0);
    rb("R4", 1, 0, 0, 0);

    // R10: write-only inputs on reads, inputs without beat_vld
    beat("R10", 1, 0, 1, 0, 0, 0, 0, 0, 4'b0000);
    beat("R10", 1, 0, 1, 1, 0, 1, 1, 1, FULL);
    beat("R10", 0, 1, 1, 0, 1, 0, 0, 0, 4'b0000);
    beat("R10", 0, 0, 1, 0, 1, 0, 0, 0, FULL);
    wb("R10", 1, 0, 0, 0);

    // R4, R5: reads interleaved in a write burst
    wb("R4", 0, 0, 1, 0); rb("R5", 1, 0, 0, 0);
    wb("R4", 1, 0, 0, 0); rb("R5", 0, 0, 0, 0);
    wb("R1", 1, 0, 0, 0); rb("R5", 1, 0, 0, 0);

    // Random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [STRB_W-1:0] s;
      s = ($urandom_range(0, 3) == 0) ? STRB_W'($urandom) : FULL;
      beat("R3", $urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0, s);
    end
    idle("R1", 2);
    @(negedge clk); compare();

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule